// File: doc/BRIEF.md
# Serial-Peripheral EEPROM Slave Engine

This block is the serial side of a byte-wide serial EEPROM, written as synthesizable logic that runs on a fast system clock. It takes chip select, serial clock, serial data in and a suspend input from the bus, and drives a serial data output together with an output enable. The bus pins are synchronised, and their edges are then detected against the system clock. The serial clock must therefore be several times slower than `clk`.

A command begins with an opcode byte. A read or write opcode is followed by a 16-bit address and then data bytes. Read data streams out of the internal array with the address advancing after each byte. Write data collects in a page buffer. The buffer is copied into the array only when chip select rises. A timed busy period follows, modelled as a clock-cycle counter; during it only the status read is accepted. The array depth, the page size, the write time and the three opcode values are parameters. The default array is kept small, and `MEM_AW = 15` gives the full 32 KiB part.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Bus modes 0 and 3 both work. SI is taken on a rising SCK edge, and SO changes only after a falling SCK edge. Chip select may fall with SCK idle low or idle high.
- R2: Opcode, address and data bytes are shifted most significant bit first, both on SI and on SO.
- R3: The first byte after chip select falls is the opcode (defaults: read 0x03, write 0x02, status read 0x05). Any other value makes the rest of the command inert: SO stays disabled and no write starts. SO is disabled whenever chip select is high.
- R4: The address is 16 bits, sent high byte first. Only the low MEM_AW bits are used and the rest are ignored. A read returns successive bytes and wraps from the top address to 0.
- R5: Write bytes are buffered and reach the array only when chip select rises. Only complete bytes count, and locations that were not sent keep their old value. A write with no complete data byte starts no write cycle.
- R6: Within one write, the address wraps inside its 2^PAGE_AW-byte page, and a later byte replaces an earlier one at the same location.
- R7: After a write's chip select rises, `busy` goes high within 4 clk cycles and stays high for exactly WR_CYCLES clk cycles.
- R8: While `busy` is high, every opcode except status read is ignored. A read drives nothing, and a write changes no data and starts no new cycle.
- R9: Status read returns a byte whose bit 0 is the busy flag and whose bits 7..1 are zero, repeated for as long as SCK runs.
- R10: While the suspend input is low, SCK and SI are ignored and SO is disabled. When it returns high, the command resumes at the same bit.
- R11: After reset, SO is disabled and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic is synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Bus chip select, active low |
| sck | input | 1 | Bus serial clock |
| si | input | 1 | Serial data from the bus master |
| hold_n | input | 1 | Suspend input, active low, changed only while SCK is low |
| so | output | 1 | Serial data to the bus master |
| so_oe | output | 1 | Output enable for `so`; low means the pin floats |
| busy | output | 1 | High during the timed internal write cycle |

## Verification
A small array of four pages is filled in both bus modes and then read back across its top address. This catches a design that does not wrap its read counter, or that decodes the upper address bits. Writes aimed at the last bytes of a page and running past it show whether the address spills into the next page instead of wrapping within it. Commands that end mid-byte or before any data show whether a partial byte is committed or a useless write cycle starts. Commands issued during the busy window, and a suspend held in the middle of a byte with SCK toggling, expose a design that accepts writes while busy or loses its bit position.

// File: rtl/eep_pkg.sv
package eep_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADR,
      ST_RD,
      ST_WR,
      ST_SR,
      ST_IGN
   } eep_state_e;

   localparam int ADDR_FIELD_W = 16;
endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
   parameter int           N       = 4,
   parameter int           STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] q
);
   initial begin
      assert (STAGES >= 1) else $error("eep_pin_sync: STAGES must be at least 1");
   end

   for (genvar b = 0; b < N; b++) begin : g_bit
      if (STAGES == 1) begin : g_single
         logic ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= RST_VAL[b];
            else        ff <= din[b];
         end
         assign q[b] = ff;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], din[b]};
         end
         assign q[b] = chain[STAGES-1];
      end
   end
endmodule

// File: rtl/eep_serial_fsm.sv
module eep_serial_fsm
   import eep_pkg::*;
#(
   parameter int         MEM_AW   = 11,
   parameter int         PAGE_AW  = 6,
   parameter logic [7:0] OP_READ  = 8'h03,
   parameter logic [7:0] OP_WRITE = 8'h02,
   parameter logic [7:0] OP_RDSR  = 8'h05
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cs_n_s,
   input  logic                      sck_s,
   input  logic                      si_s,
   input  logic                      hold_s,
   input  logic                      busy,
   input  logic [7:0]                rd_data,
   output logic [MEM_AW-1:0]         rd_addr,
   output logic                      so_q,
   output logic                      so_oe,
   output logic                      buf_we,
   output logic [PAGE_AW-1:0]        buf_idx,
   output logic [7:0]                buf_wdata,
   output logic                      buf_clr,
   output logic                      commit_req,
   output logic [MEM_AW-PAGE_AW-1:0] commit_page
);
   localparam int SH_W = (MEM_AW - 1 > 7) ? MEM_AW - 1 : 7;

   initial begin
      assert (MEM_AW <= ADDR_FIELD_W - 1) else $error("eep_serial_fsm: MEM_AW too large");
      assert (MEM_AW > PAGE_AW)           else $error("eep_serial_fsm: page larger than array");
      assert (PAGE_AW >= 1)               else $error("eep_serial_fsm: PAGE_AW must be positive");
      assert (OP_READ != OP_WRITE && OP_READ != OP_RDSR && OP_WRITE != OP_RDSR)
         else $error("eep_serial_fsm: opcodes must differ");
   end

   eep_state_e        st;
   logic [3:0]        cnt;
   logic [SH_W-1:0]   sh;
   logic [MEM_AW-1:0] addr;
   logic              is_wr;
   logic              got_byte;
   logic [7:0]        tx_byte;
   logic              sck_d, cs_d;

   logic              sck_rise, sck_fall, cs_rise;
   logic [7:0]        rx_byte;
   logic [MEM_AW-1:0] rx_addr;
   logic [7:0]        tx_src;
   logic              tx_phase;

   assign sck_rise = sck_s & ~sck_d;
   assign sck_fall = ~sck_s & sck_d;
   assign cs_rise  = cs_n_s & ~cs_d;
   assign rx_byte  = {sh[6:0], si_s};
   assign rx_addr  = {sh[MEM_AW-2:0], si_s};
   assign tx_phase = (st == ST_RD) || (st == ST_SR);
   assign tx_src   = (st == ST_RD) ? rd_data : {7'd0, busy};

   assign rd_addr     = addr;
   assign commit_page = addr[MEM_AW-1:PAGE_AW];
   assign so_oe       = !cs_n_s && hold_s && tx_phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         cs_d  <= 1'b1;
      end else begin
         sck_d <= sck_s;
         cs_d  <= cs_n_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cnt        <= '0;
         sh         <= '0;
         addr       <= '0;
         is_wr      <= 1'b0;
         got_byte   <= 1'b0;
         tx_byte    <= '0;
         so_q       <= 1'b0;
         buf_we     <= 1'b0;
         buf_idx    <= '0;
         buf_wdata  <= '0;
         buf_clr    <= 1'b0;
         commit_req <= 1'b0;
      end else begin
         buf_we     <= 1'b0;
         buf_clr    <= 1'b0;
         commit_req <= 1'b0;
         if (cs_n_s) begin
            if (cs_rise && st == ST_WR && got_byte) commit_req <= 1'b1;
            st  <= ST_IDLE;
            cnt <= '0;
         end else if (st == ST_IDLE) begin
            st       <= ST_OPC;
            cnt      <= '0;
            got_byte <= 1'b0;
         end else if (hold_s) begin
            if (sck_rise) begin
               sh <= {sh[SH_W-2:0], si_s};
               case (st)
                  ST_OPC: begin
                     if (cnt == 4'd7) begin
                        cnt <= '0;
                        if (busy && rx_byte != OP_RDSR) begin
                           st <= ST_IGN;
                        end else if (rx_byte == OP_READ) begin
                           st    <= ST_ADR;
                           is_wr <= 1'b0;
                        end else if (rx_byte == OP_WRITE) begin
                           st      <= ST_ADR;
                           is_wr   <= 1'b1;
                           buf_clr <= 1'b1;
                        end else if (rx_byte == OP_RDSR) begin
                           st <= ST_SR;
                        end else begin
                           st <= ST_IGN;
                        end
                     end else begin
                        cnt <= cnt + 4'd1;
                     end
                  end
                  ST_ADR: begin
                     if (cnt == 4'd15) begin
                        cnt  <= '0;
                        addr <= rx_addr;
                        st   <= is_wr ? ST_WR : ST_RD;
                     end else begin
                        cnt <= cnt + 4'd1;
                     end
                  end
                  ST_WR: begin
                     if (cnt == 4'd7) begin
                        cnt       <= '0;
                        buf_we    <= 1'b1;
                        buf_idx   <= addr[PAGE_AW-1:0];
                        buf_wdata <= rx_byte;
                        addr      <= {addr[MEM_AW-1:PAGE_AW], addr[PAGE_AW-1:0] + 1'b1};
                        got_byte  <= 1'b1;
                     end else begin
                        cnt <= cnt + 4'd1;
                     end
                  end
                  ST_RD: begin
                     if (cnt == 4'd7) begin
                        cnt  <= '0;
                        addr <= addr + 1'b1;
                     end else begin
                        cnt <= cnt + 4'd1;
                     end
                  end
                  default: begin
                     cnt <= (cnt == 4'd7) ? 4'd0 : cnt + 4'd1;
                  end
               endcase
            end else if (sck_fall && tx_phase) begin
               if (cnt == 4'd0) begin
                  tx_byte <= tx_src;
                  so_q    <= tx_src[7];
               end else begin
                  so_q <= tx_byte[3'd7 - cnt[2:0]];
               end
            end
         end
      end
   end

   AST_BUF_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> !busy);  // R8
   AST_COMMIT_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req |-> cs_n_s);  // R5
   AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_s && !hold_s && st != ST_IDLE) |=> (cs_n_s || $stable(cnt)));  // R10
   AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (so_oe && !sck_fall) |=> $stable(so_q));  // R1
endmodule

// File: rtl/eep_page_commit.sv
module eep_page_commit #(
   parameter int PAGE_AW   = 6,
   parameter int PGW       = 5,
   parameter int WR_CYCLES = 1000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   buf_we,
   input  logic [PAGE_AW-1:0]     buf_idx,
   input  logic [7:0]             buf_wdata,
   input  logic                   buf_clr,
   input  logic                   commit_req,
   input  logic [PGW-1:0]         commit_page,
   output logic                   busy,
   output logic                   arr_we,
   output logic [PGW+PAGE_AW-1:0] arr_waddr,
   output logic [7:0]             arr_wdata
);
   localparam int            PAGE_BYTES = 1 << PAGE_AW;
   localparam int            TW         = $clog2(WR_CYCLES + 1);
   localparam logic [TW-1:0] LAST_T     = TW'(WR_CYCLES - 1);
   localparam logic [TW-1:0] PB_T       = TW'(PAGE_BYTES);

   initial begin
      assert (WR_CYCLES >= PAGE_BYTES) else $error("eep_page_commit: WR_CYCLES shorter than a page");
   end

   logic [7:0]            pbuf [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] pvalid;
   logic [TW-1:0]         tmr;
   logic [PGW-1:0]        pg;
   logic [PAGE_AW-1:0]    slot;

   assign slot      = tmr[PAGE_AW-1:0];
   assign arr_we    = busy && (tmr < PB_T) && pvalid[slot];
   assign arr_waddr = {pg, slot};
   assign arr_wdata = pbuf[slot];

   always_ff @(posedge clk) begin
      if (buf_we) pbuf[buf_idx] <= buf_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pvalid <= '0;
      else if (buf_clr) pvalid <= '0;
      else if (buf_we)  pvalid[buf_idx] <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         tmr  <= '0;
         pg   <= '0;
      end else if (commit_req) begin
         busy <= 1'b1;
         tmr  <= '0;
         pg   <= commit_page;
      end else if (busy) begin
         if (tmr == LAST_T) busy <= 1'b0;
         tmr <= tmr + TW'(1);
      end
   end

   AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(commit_req));  // R7
   AST_NO_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req |-> !busy);  // R8
   AST_NO_FILL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(buf_we || buf_clr));  // R8
endmodule

// File: rtl/eep_mem_array.sv
module eep_mem_array #(
   parameter int AW = 11
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   localparam int DEPTH = 1 << AW;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
   parameter int         MEM_AW      = 11,
   parameter int         PAGE_AW     = 6,
   parameter int         WR_CYCLES   = 1000,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] OP_READ     = 8'h03,
   parameter logic [7:0] OP_WRITE    = 8'h02,
   parameter logic [7:0] OP_RDSR     = 8'h05
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   input  logic hold_n,
   output logic so,
   output logic so_oe,
   output logic busy
);
   localparam int PGW = MEM_AW - PAGE_AW;

   logic [3:0]        pins_s;
   logic [MEM_AW-1:0] rd_addr;
   logic [7:0]        rd_data;
   logic              buf_we, buf_clr, commit_req;
   logic [PAGE_AW-1:0] buf_idx;
   logic [7:0]        buf_wdata;
   logic [PGW-1:0]    commit_page;
   logic              arr_we;
   logic [MEM_AW-1:0] arr_waddr;
   logic [7:0]        arr_wdata;

   eep_pin_sync #(
      .N       (4),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (4'b1100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({cs_n, hold_n, sck, si}),
      .q     (pins_s)
   );

   eep_serial_fsm #(
      .MEM_AW   (MEM_AW),
      .PAGE_AW  (PAGE_AW),
      .OP_READ  (OP_READ),
      .OP_WRITE (OP_WRITE),
      .OP_RDSR  (OP_RDSR)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n_s      (pins_s[3]),
      .hold_s      (pins_s[2]),
      .sck_s       (pins_s[1]),
      .si_s        (pins_s[0]),
      .busy        (busy),
      .rd_data     (rd_data),
      .rd_addr     (rd_addr),
      .so_q        (so),
      .so_oe       (so_oe),
      .buf_we      (buf_we),
      .buf_idx     (buf_idx),
      .buf_wdata   (buf_wdata),
      .buf_clr     (buf_clr),
      .commit_req  (commit_req),
      .commit_page (commit_page)
   );

   eep_page_commit #(
      .PAGE_AW   (PAGE_AW),
      .PGW       (PGW),
      .WR_CYCLES (WR_CYCLES)
   ) u_commit (
      .clk         (clk),
      .rst_n       (rst_n),
      .buf_we      (buf_we),
      .buf_idx     (buf_idx),
      .buf_wdata   (buf_wdata),
      .buf_clr     (buf_clr),
      .commit_req  (commit_req),
      .commit_page (commit_page),
      .busy        (busy),
      .arr_we      (arr_we),
      .arr_waddr   (arr_waddr),
      .arr_wdata   (arr_wdata)
   );

   eep_mem_array #(
      .AW (MEM_AW)
   ) u_array (
      .clk   (clk),
      .we    (arr_we),
      .waddr (arr_waddr),
      .wdata (arr_wdata),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);  // R3
endmodule

// File: tb/sim_spi_eeprom_slave.sv
module sim_spi_eeprom_slave;
   localparam int         MEM_AW = 8;
   localparam int         WR     = 2500;
   localparam int         HALF   = 6;
   localparam logic [7:0] OP_RD  = 8'h03;
   localparam logic [7:0] OP_WR  = 8'h02;
   localparam logic [7:0] OP_SR  = 8'h05;

   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
   logic so, so_oe, busy;

   int   n_chk = 0, n_err = 0;
   bit   m3 = 1'b0, oe_any = 1'b0, done = 1'b0;
   logic [7:0] exp_mem [256];

   always #2 clk = ~clk;

   spi_eeprom_slave #(
      .MEM_AW (MEM_AW), .PAGE_AW (6), .WR_CYCLES (WR), .SYNC_STAGES (2),
      .OP_READ (OP_RD), .OP_WRITE (OP_WR), .OP_RDSR (OP_SR)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sck (sck), .si (si),
      .hold_n (hold_n), .so (so), .so_oe (so_oe), .busy (busy)
   );

   function automatic logic [7:0] pat(input int s, input int k);
      return 8'((s * 53 + k * 29 + k / 3) ^ (s << 3) ^ 8'h3C);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_x(input logic b, output logic r);
      sck = 1'b0; si = b; tick(HALF);
      r = so; oe_any |= so_oe;
      sck = 1'b1; tick(HALF);
   endtask

   task automatic byte_x(input logic [7:0] tx, input int hold_at, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         if (i == hold_at) begin
            sck = 1'b0; tick(HALF);
            hold_n = 1'b0; tick(HALF);
            check(so_oe == 1'b0, "R10", so_oe, 0);
            for (int j = 0; j < 3; j++) begin
               si = ~si; sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
            end
            hold_n = 1'b1; tick(HALF);
         end
         bit_x(tx[i], rx[i]);
      end
   endtask

   task automatic start();
      sck = m3; cs_n = 1'b0; oe_any = 1'b0; tick(HALF);
   endtask

   task automatic stop();
      if (!m3) sck = 1'b0;
      tick(HALF);
      cs_n = 1'b1;
   endtask

   task automatic send_head(input logic [7:0] op, input logic [15:0] a);
      logic [7:0] rx;
      byte_x(op, -1, rx);
      byte_x(a[15:8], -1, rx);
      byte_x(a[7:0], -1, rx);
   endtask

   task automatic write_cmd(input logic [15:0] a, input int n, input int seed,
                            input bit apply, input int hold_k);
      logic [7:0] d, rx;
      logic [5:0] off;
      start();
      send_head(OP_WR, a);
      off = a[5:0];
      for (int k = 0; k < n; k++) begin
         d = pat(seed, k);
         byte_x(d, (k == hold_k) ? 5 : -1, rx);
         if (apply) exp_mem[{a[7:6], off}] = d;
         off = off + 6'd1;
      end
      stop();
   endtask

   task automatic wait_done();
      int n = 0;
      do begin
         tick(1); n++;
         if (n == 8) check(busy == 1'b1, "R7", busy, 1);
      end while ((busy || n < 8) && n < WR + 100);
      check(n >= WR + 2 && n <= WR + 8, "R7", n, WR + 4);
      tick(4);
   endtask

   task automatic read_cmd(input logic [15:0] a, input int n, input int hold_k, input string tag);
      logic [7:0] rx, e;
      start();
      send_head(OP_RD, a);
      for (int k = 0; k < n; k++) begin
         byte_x(8'h00, (k == hold_k) ? 3 : -1, rx);
         e = exp_mem[8'(a + 16'(k))];
         check(rx == e, tag, rx, e);
      end
      stop();
      tick(4);
   endtask

   task automatic status_cmd(input logic [7:0] expv);
      logic [7:0] rx;
      start();
      byte_x(OP_SR, -1, rx);
      for (int k = 0; k < 2; k++) begin
         byte_x(8'h00, -1, rx);
         check(rx == expv, "R9", rx, expv);
      end
      stop();
      tick(4);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual 190000 cycles expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] rx, d;
      logic       r;
      tick(4); rst_n = 1'b1; tick(5);
      check(so_oe == 1'b0, "R11", so_oe, 0);
      check(busy == 1'b0, "R11", busy, 0);

      // fill all four pages, alternating bus modes
      for (int p = 0; p < 4; p++) begin
         m3 = p[0];
         write_cmd(16'(p * 64), 64, p + 1, 1'b1, -1);
         wait_done();
      end
      m3 = 1'b0;
      read_cmd(16'h0000, 260, -1, "R2");
      m3 = 1'b1;
      read_cmd(16'h7F05, 8, -1, "R1");
      read_cmd(16'h80FE, 4, -1, "R4");

      // partial page write in mode 0
      m3 = 1'b0;
      write_cmd(16'h0045, 3, 9, 1'b1, -1);
      wait_done();
      read_cmd(16'h0040, 64, -1, "R5");

      // run past the end of a page in mode 3
      m3 = 1'b1;
      write_cmd(16'h00BE, 66, 11, 1'b1, -1);
      wait_done();
      read_cmd(16'h0080, 64, -1, "R6");

      // no complete data byte: no write cycle
      m3 = 1'b0;
      start();
      send_head(OP_WR, 16'h0010);
      for (int i = 0; i < 5; i++) bit_x(1'b1, r);
      stop();
      tick(30);
      check(busy == 1'b0, "R5", busy, 0);
      read_cmd(16'h0010, 1, -1, "R5");

      // two bytes then a trailing partial byte
      start();
      send_head(OP_WR, 16'h0020);
      for (int k = 0; k < 2; k++) begin
         d = pat(21, k);
         byte_x(d, -1, rx);
         exp_mem[8'h20 + 8'(k)] = d;
      end
      for (int i = 0; i < 3; i++) bit_x(1'b0, r);
      stop();
      wait_done();
      read_cmd(16'h0020, 3, -1, "R5");

      // commands issued during the busy window
      write_cmd(16'h00C0, 1, 13, 1'b1, -1);
      tick(10);
      status_cmd(8'h01);
      start();
      send_head(OP_RD, 16'h0000);
      byte_x(8'h00, -1, rx);
      stop();
      check(oe_any == 1'b0, "R8", oe_any, 0);
      tick(4);
      write_cmd(16'h0000, 2, 99, 1'b0, -1);
      check(busy == 1'b1, "R8", busy, 1);
      begin
         int n = 0;
         while (busy && n < WR + 100) begin tick(1); n++; end
      end
      tick(20);
      check(busy == 1'b0, "R8", busy, 0);
      read_cmd(16'h0000, 2, -1, "R8");
      read_cmd(16'h00C0, 1, -1, "R5");
      status_cmd(8'h00);

      // suspend in mid-byte during a read and during a write
      read_cmd(16'h0040, 4, 1, "R10");
      m3 = 1'b1;
      write_cmd(16'h0030, 2, 31, 1'b1, 0);
      wait_done();
      read_cmd(16'h0030, 2, -1, "R10");

      // unknown opcode
      m3 = 1'b0;
      start();
      send_head(8'hA5, 16'h0000);
      byte_x(8'h00, -1, rx);
      stop();
      check(oe_any == 1'b0, "R3", oe_any, 0);
      tick(20);
      check(busy == 1'b0, "R3", busy, 0);
      check(so_oe == 1'b0, "R3", so_oe, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule